// File: doc/BRIEF.md
# ATAPI PIO Data Burst Mover

This block carries out one programmed-I/O data burst between a byte-wide buffer stream and the 16-bit data register of a packet-command storage device. A phase sequencer pulses `start` with the burst direction, the device's two byte-count register values and the host's remaining byte count. The mover works out how many bytes to move: the smaller of the device count and the host count. It moves them as whole 16-bit words, with the earlier buffer byte in the low half. It then reports the new remaining count with a one-cycle `done`.

An odd final byte is handled inside one word. On a read, the last word is fetched and only its low byte reaches the buffer. On a write, the last byte is written with a zero upper half. On a read, device words that the host cannot take are still read from the device and then discarded, so the device always sees its full count drained. Device register timing is reduced to a request/acknowledge word strobe. The buffer is reduced to two valid/ready byte streams.

The controller has eight states. `ST_IDLE` waits for `start`. On a read it goes to `ST_DEV_RD`, or to `ST_FIN` when the device count is zero. On a write it goes to `ST_PULL_LO`, or to `ST_FIN` when the burst size is zero. `ST_DEV_RD` fetches a word. It goes to `ST_PUSH_LO` while buffer bytes remain, and otherwise drains further words until the last one, then goes to `ST_FIN`. `ST_PUSH_LO` goes to `ST_PUSH_HI`. When that byte was the final one, it goes instead to `ST_DEV_RD` to drain, or to `ST_FIN`. `ST_PUSH_HI` goes to `ST_DEV_RD`, or to `ST_FIN` once no device words are left. `ST_PULL_LO` goes to `ST_PULL_HI`, or straight to `ST_DEV_WR` on an odd final byte. `ST_PULL_HI` goes to `ST_DEV_WR`. `ST_DEV_WR` goes back to `ST_PULL_LO`, or to `ST_FIN` after the last word. `ST_FIN` asserts `done` and returns to `ST_IDLE`.

Top module: `pio_burst_mover`

## Requirements
- R1: At `start` the device byte count is taken as `cnt_hi`*256 + `cnt_lo`.
- R2: The burst size is the minimum of `host_rem` and the device byte count; exactly that many bytes cross the buffer interface.
- R3: In every device word the low byte (bits 7:0) is the earlier byte in buffer order and bits 15:8 the following byte.
- R4: On a read with an odd burst size, the final word is read from the device and only its low byte is pushed to the buffer.
- R5: On a write with an odd burst size, the final word written carries the last byte in bits 7:0 and zero in bits 15:8.
- R6: On a read the device is read exactly ceil(device count / 2) times; words beyond the burst are discarded and never pushed.
- R7: On a write exactly ceil(burst size / 2) words are written, and no buffer byte beyond the burst size is pulled.
- R8: In the `done` cycle `rem_left` equals `host_rem` minus the burst size, and `xferred` is 1 from then until reset.
- R9: `done` is high for exactly one cycle, in the cycle after the final handshake of the burst.
- R10: A zero-length burst (device count zero on a read, burst size zero on a write) raises `done` in the cycle after `start` with no device or buffer access.
- R11: A `start` received while `busy` is high is ignored and does not alter the burst in progress.
- R12: Once `dev_req` is raised it stays high, with `dev_wr` and `dev_wdata` unchanged, until `dev_ack` is seen.
- R13: After reset the block is idle: `dev_req`, `push_valid`, `pull_ready`, `done`, `busy`, `xferred` low and `rem_left` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a burst (taken only when idle) |
| rd_dir | input | 1 | 1 = device to buffer, 0 = buffer to device |
| cnt_hi | input | 8 | Device byte count, upper register value |
| cnt_lo | input | 8 | Device byte count, lower register value |
| host_rem | input | HOST_W | Host bytes still outstanding |
| dev_req | output | 1 | Device word access request |
| dev_wr | output | 1 | Access is a write |
| dev_wdata | output | 16 | Word written to the device |
| dev_rdata | input | 16 | Word returned by the device |
| dev_ack | input | 1 | Device completes the access this cycle |
| push_valid | output | 1 | Byte offered to the buffer |
| push_data | output | 8 | Byte to the buffer |
| push_ready | input | 1 | Buffer takes the byte |
| pull_valid | input | 1 | Buffer offers a byte |
| pull_data | input | 8 | Byte from the buffer |
| pull_ready | output | 1 | Mover takes the byte |
| done | output | 1 | One-cycle burst completion |
| busy | output | 1 | A burst is in progress |
| rem_left | output | HOST_W | Host remaining count after the last burst |
| xferred | output | 1 | Sticky data-transferred flag |

## Verification
The assertions assume that the buffer and the device answer only through their handshakes. They also assume that `start` arrives with its count and direction inputs settled in that cycle, and that `host_rem` fits the configured width. The bench holds to this by driving every input on the falling edge. It raises `dev_ack`, `push_ready` and `pull_valid` only from its own reference model, sometimes every cycle and sometimes by a pseudo-random pattern. It also tries a second `start` partway through a long burst.

// File: rtl/pio_mover_pkg.sv
package pio_mover_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV_RD,
        ST_PUSH_LO,
        ST_PUSH_HI,
        ST_PULL_LO,
        ST_PULL_HI,
        ST_DEV_WR,
        ST_FIN
    } mover_state_e;

endpackage

// File: rtl/pio_burst_sizer.sv
module pio_burst_sizer #(
    parameter int BYTE_W = 8,
    parameter int HOST_W = 20
) (
    input  logic [BYTE_W-1:0]   cnt_hi,
    input  logic [BYTE_W-1:0]   cnt_lo,
    input  logic [HOST_W-1:0]   host_rem,
    output logic [2*BYTE_W-1:0] dev_bytes,
    output logic [2*BYTE_W-1:0] xfer_bytes,
    output logic [2*BYTE_W-1:0] dev_words,
    output logic [2*BYTE_W-1:0] xfer_words
);
    localparam int DEV_W = 2 * BYTE_W;
    localparam int CMP_W = (HOST_W > DEV_W) ? HOST_W : DEV_W;

    logic [CMP_W-1:0] dev_ext;
    logic [CMP_W-1:0] host_ext;
    logic [DEV_W:0]   dev_round;
    logic [DEV_W:0]   xfer_round;

    always_comb begin
        dev_bytes  = {cnt_hi, cnt_lo};
        dev_ext    = CMP_W'(dev_bytes);
        host_ext   = CMP_W'(host_rem);
        xfer_bytes = (host_ext < dev_ext) ? DEV_W'(host_ext) : dev_bytes;
        // word counts round an odd byte up to a whole word
        dev_round  = ({1'b0, dev_bytes} + (DEV_W+1)'(1)) >> 1;
        xfer_round = ({1'b0, xfer_bytes} + (DEV_W+1)'(1)) >> 1;
        dev_words  = dev_round[DEV_W-1:0];
        xfer_words = xfer_round[DEV_W-1:0];
    end

endmodule

// File: rtl/pio_word_lane.sv
module pio_word_lane #(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cap_word,
    input  logic [2*BYTE_W-1:0] word_in,
    input  logic                set_lo,
    input  logic                set_hi,
    input  logic [BYTE_W-1:0]   byte_in,
    output logic [2*BYTE_W-1:0] word_q,
    output logic [BYTE_W-1:0]   lo_byte,
    output logic [BYTE_W-1:0]   hi_byte
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (cap_word) begin
            word_q <= word_in;
        end else if (set_lo) begin
            // a fresh low byte clears the upper half, giving the zero pad
            word_q <= {{BYTE_W{1'b0}}, byte_in};
        end else if (set_hi) begin
            word_q <= {byte_in, word_q[BYTE_W-1:0]};
        end
    end

    assign lo_byte = word_q[BYTE_W-1:0];
    assign hi_byte = word_q[2*BYTE_W-1:BYTE_W];

    // R3: the earlier byte is kept when the later one arrives
    p_hi_keeps_lo_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (set_hi && !cap_word && !set_lo) |=> (lo_byte == $past(lo_byte)));

endmodule

// File: rtl/pio_burst_mover.sv
module pio_burst_mover
    import pio_mover_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int HOST_W = 20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                rd_dir,
    input  logic [BYTE_W-1:0]   cnt_hi,
    input  logic [BYTE_W-1:0]   cnt_lo,
    input  logic [HOST_W-1:0]   host_rem,
    output logic                dev_req,
    output logic                dev_wr,
    output logic [2*BYTE_W-1:0] dev_wdata,
    input  logic [2*BYTE_W-1:0] dev_rdata,
    input  logic                dev_ack,
    output logic                push_valid,
    output logic [BYTE_W-1:0]   push_data,
    input  logic                push_ready,
    input  logic                pull_valid,
    input  logic [BYTE_W-1:0]   pull_data,
    output logic                pull_ready,
    output logic                done,
    output logic                busy,
    output logic [HOST_W-1:0]   rem_left,
    output logic                xferred
);
    localparam int DEV_W = 2 * BYTE_W;

    mover_state_e state_q, state_d;

    logic [DEV_W-1:0]  bytes_left_q;
    logic [DEV_W-1:0]  words_left_q;
    logic [DEV_W-1:0]  xfer_q;
    logic [HOST_W-1:0] rem_base_q;
    logic [HOST_W-1:0] rem_left_q;
    logic              xferred_q;

    logic [DEV_W-1:0]  sz_dev_bytes, sz_xfer_bytes, sz_dev_words, sz_xfer_words;
    logic [DEV_W-1:0]  lane_word;
    logic [BYTE_W-1:0] lane_lo, lane_hi;

    logic dev_fire, push_fire, pull_fire, take_start;

    pio_burst_sizer #(.BYTE_W(BYTE_W), .HOST_W(HOST_W)) u_sizer (
        .cnt_hi     (cnt_hi),
        .cnt_lo     (cnt_lo),
        .host_rem   (host_rem),
        .dev_bytes  (sz_dev_bytes),
        .xfer_bytes (sz_xfer_bytes),
        .dev_words  (sz_dev_words),
        .xfer_words (sz_xfer_words)
    );

    pio_word_lane #(.BYTE_W(BYTE_W)) u_lane (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_word (state_q == ST_DEV_RD && dev_fire),
        .word_in  (dev_rdata),
        .set_lo   (state_q == ST_PULL_LO && pull_fire),
        .set_hi   (state_q == ST_PULL_HI && pull_fire),
        .byte_in  (pull_data),
        .word_q   (lane_word),
        .lo_byte  (lane_lo),
        .hi_byte  (lane_hi)
    );

    assign dev_fire   = dev_req && dev_ack;
    assign push_fire  = push_valid && push_ready;
    assign pull_fire  = pull_ready && pull_valid;
    assign take_start = (state_q == ST_IDLE) && start;

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    if (rd_dir) state_d = (sz_dev_bytes == '0) ? ST_FIN : ST_DEV_RD;
                    else        state_d = (sz_xfer_bytes == '0) ? ST_FIN : ST_PULL_LO;
                end
            end
            ST_DEV_RD: begin
                if (dev_fire) begin
                    if (bytes_left_q != '0)                 state_d = ST_PUSH_LO;
                    else if (words_left_q == DEV_W'(1))     state_d = ST_FIN;
                end
            end
            ST_PUSH_LO: begin
                if (push_fire) begin
                    if (bytes_left_q == DEV_W'(1))
                        state_d = (words_left_q == '0) ? ST_FIN : ST_DEV_RD;
                    else
                        state_d = ST_PUSH_HI;
                end
            end
            ST_PUSH_HI: begin
                if (push_fire) state_d = (words_left_q == '0) ? ST_FIN : ST_DEV_RD;
            end
            ST_PULL_LO: begin
                if (pull_fire) state_d = (bytes_left_q == DEV_W'(1)) ? ST_DEV_WR : ST_PULL_HI;
            end
            ST_PULL_HI: begin
                if (pull_fire) state_d = ST_DEV_WR;
            end
            ST_DEV_WR: begin
                if (dev_fire) state_d = (bytes_left_q == '0) ? ST_FIN : ST_PULL_LO;
            end
            ST_FIN:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and burst counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            bytes_left_q <= '0;
            words_left_q <= '0;
            xfer_q       <= '0;
            rem_base_q   <= '0;
            rem_left_q   <= '0;
            xferred_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (take_start) begin
                bytes_left_q <= sz_xfer_bytes;
                words_left_q <= rd_dir ? sz_dev_words : sz_xfer_words;
                xfer_q       <= sz_xfer_bytes;
                rem_base_q   <= host_rem;
            end else begin
                if (dev_fire)               words_left_q <= words_left_q - DEV_W'(1);
                if (push_fire || pull_fire) bytes_left_q <= bytes_left_q - DEV_W'(1);
            end
            if (state_d == ST_FIN && state_q != ST_FIN) begin
                rem_left_q <= (state_q == ST_IDLE) ? host_rem - HOST_W'(sz_xfer_bytes)
                                                   : rem_base_q - HOST_W'(xfer_q);
                xferred_q  <= 1'b1;
            end
        end
    end

    // outputs from state
    always_comb begin
        dev_req    = 1'b0;
        dev_wr     = 1'b0;
        push_valid = 1'b0;
        pull_ready = 1'b0;
        push_data  = lane_lo;
        unique case (state_q)
            ST_DEV_RD:  dev_req = 1'b1;
            ST_DEV_WR:  begin dev_req = 1'b1; dev_wr = 1'b1; end
            ST_PUSH_LO: push_valid = 1'b1;
            ST_PUSH_HI: begin push_valid = 1'b1; push_data = lane_hi; end
            ST_PULL_LO, ST_PULL_HI: pull_ready = 1'b1;
            default: ;
        endcase
    end

    assign dev_wdata = lane_word;
    assign done      = (state_q == ST_FIN);
    assign busy      = (state_q != ST_IDLE);
    assign rem_left  = rem_left_q;
    assign xferred   = xferred_q;

    // R12: an unanswered strobe is held unchanged
    p_strobe_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_req && !dev_ack) |=> (dev_req && $stable(dev_wr) && $stable(dev_wdata)));

    // R9: completion is a single-cycle pulse
    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5: the last word of an odd write has a zero upper byte
    p_odd_pad_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_req && dev_wr && bytes_left_q == '0 && xfer_q[0]) |-> (dev_wdata[2*BYTE_W-1:BYTE_W] == '0));

    // R6: no byte is pushed once the burst share is used up
    p_push_in_burst_r6: assert property (@(posedge clk) disable iff (!rst_n)
        push_valid |-> (bytes_left_q != '0));

    // R7: a write ends on its last counted word
    p_write_words_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_req && dev_wr && dev_ack && bytes_left_q == '0) |-> (words_left_q == DEV_W'(1)));

    // R8: the flag is present when completion is signalled
    p_flag_at_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> xferred);

    // R11: a start during a burst leaves the burst size alone
    p_busy_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(xfer_q));

endmodule

// File: tb/pio_burst_mover_bench.sv
module pio_burst_mover_bench;
    localparam int CLK_PERIOD = 10;
    localparam int HW = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        rd_dir = 1'b0;
    logic [7:0]  cnt_hi = '0, cnt_lo = '0;
    logic [HW-1:0] host_rem = '0;
    logic        dev_req, dev_wr;
    logic [15:0] dev_wdata;
    logic [15:0] dev_rdata = '0;
    logic        dev_ack = 1'b0;
    logic        push_valid;
    logic [7:0]  push_data;
    logic        push_ready = 1'b0;
    logic        pull_valid = 1'b0;
    logic [7:0]  pull_data = '0;
    logic        pull_ready, done, busy, xferred;
    logic [HW-1:0] rem_left;

    always #(CLK_PERIOD/2) clk = ~clk;

    pio_burst_mover #(.BYTE_W(8), .HOST_W(HW)) u_pio_burst_mover (
        .clk(clk), .rst_n(rst_n), .start(start), .rd_dir(rd_dir),
        .cnt_hi(cnt_hi), .cnt_lo(cnt_lo), .host_rem(host_rem),
        .dev_req(dev_req), .dev_wr(dev_wr), .dev_wdata(dev_wdata),
        .dev_rdata(dev_rdata), .dev_ack(dev_ack),
        .push_valid(push_valid), .push_data(push_data), .push_ready(push_ready),
        .pull_valid(pull_valid), .pull_data(pull_data), .pull_ready(pull_ready),
        .done(done), .busy(busy), .rem_left(rem_left), .xferred(xferred)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    // reference model state
    logic [15:0] word_q[$];
    logic [7:0]  byte_q[$];
    int          hs_left = 0;
    bit          done_due = 0;
    bit          done_seen = 0;
    bit          slow = 0;
    logic [15:0] lfsr = 16'hACE1;
    bit          req_waiting = 0;
    logic [15:0] held_wdata = '0;
    logic        held_wr = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    function automatic logic [7:0] pat(input int seed, input int k);
        return 8'((seed * 37) + (k * 11) + 5);
    endfunction

    // per-clock reference comparison and handshake answers
    always @(negedge clk) begin
        if (rst_n) begin
            if (done !== done_due) chk(0, "R9 done timing", int'(done), int'(done_due));
            else if (done_due)     chk(1, "R9 done timing", 1, 1);
            if (done) done_seen = 1;
            done_due = 0;

            if (req_waiting)
                chk(dev_req && dev_wr == held_wr && dev_wdata == held_wdata,
                    "R12 strobe hold", int'(dev_wdata), int'(held_wdata));

            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            dev_ack    = 1'b0;
            push_ready = 1'b0;
            pull_valid = 1'b0;

            if (dev_req && (!slow || lfsr[0] || lfsr[3])) begin
                dev_ack = 1'b1;
                if (dev_wr) begin
                    if (word_q.size() == 0) chk(0, "R7 extra device write", int'(dev_wdata), -1);
                    else begin
                        logic [15:0] w;
                        w = word_q.pop_front();
                        chk(dev_wdata == w, "R3/R5 written word", int'(dev_wdata), int'(w));
                    end
                end else begin
                    if (word_q.size() == 0) chk(0, "R6 extra device read", 1, 0);
                    else dev_rdata = word_q.pop_front();
                end
                hs_left--;
                if (hs_left == 0) done_due = 1;
            end else if (push_valid && (!slow || lfsr[1] || lfsr[4])) begin
                push_ready = 1'b1;
                if (byte_q.size() == 0) chk(0, "R6 extra pushed byte", int'(push_data), -1);
                else begin
                    logic [7:0] b;
                    b = byte_q.pop_front();
                    chk(push_data == b, "R3/R4 pushed byte", int'(push_data), int'(b));
                end
                hs_left--;
                if (hs_left == 0) done_due = 1;
            end else if (pull_ready && (!slow || lfsr[2] || lfsr[5])) begin
                pull_valid = 1'b1;
                if (byte_q.size() == 0) begin
                    chk(0, "R7 extra pulled byte", 1, 0);
                    pull_data = 8'h00;
                end else pull_data = byte_q.pop_front();
                hs_left--;
                if (hs_left == 0) done_due = 1;
            end

            req_waiting = dev_req && !dev_ack;
            held_wdata  = dev_wdata;
            held_wr     = dev_wr;
        end
    end

    task automatic run_burst(input bit rd, input int dev, input int rem,
                             input bit slw, input bit poke, input int seed);
        int n;
        n = (rem < dev) ? rem : dev;
        word_q.delete();
        byte_q.delete();
        slow = slw;
        if (rd) begin
            for (int i = 0; i < (dev + 1) / 2; i++) word_q.push_back({pat(seed, 2*i+1), pat(seed, 2*i)});
            for (int k = 0; k < n; k++) byte_q.push_back(pat(seed, k));
            hs_left = (dev + 1) / 2 + n;
        end else begin
            for (int k = 0; k < n; k++) byte_q.push_back(pat(seed, k));
            for (int w = 0; w < (n + 1) / 2; w++)
                word_q.push_back({(2*w+1 < n) ? pat(seed, 2*w+1) : 8'h00, pat(seed, 2*w)});
            hs_left = (n + 1) / 2 + n;
        end
        @(negedge clk);
        rd_dir = rd; cnt_hi = 8'(dev >> 8); cnt_lo = 8'(dev); host_rem = HW'(rem);
        start = 1'b1; done_seen = 0;
        @(posedge clk);
        if (hs_left == 0) done_due = 1;   // R10: done follows start directly
        @(negedge clk);
        start = 1'b0;
        for (int c = 0; c < 4000 && !done_seen; c++) begin
            if (poke && c == 2) begin
                start = 1'b1; rd_dir = !rd; cnt_hi = 8'h00; cnt_lo = 8'h33; host_rem = HW'(7);
            end else if (poke && c == 3) begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        chk(done_seen, "R9 burst completed", int'(done_seen), 1);
        chk(rem_left == HW'(rem - n), "R8 remaining count", int'(rem_left), rem - n);
        chk(xferred == 1'b1, "R8 transferred flag", int'(xferred), 1);
        chk(word_q.size() == 0, "R6/R7 device word total", word_q.size(), 0);
        chk(byte_q.size() == 0, "R2 byte total", byte_q.size(), 0);
        chk(!busy, "R9 idle after done", int'(busy), 0);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R13: reset state
        chk(!dev_req && !push_valid && !pull_ready, "R13 no access in reset", int'(dev_req), 0);
        chk(!done && !busy && !xferred, "R13 idle flags in reset", int'(busy), 0);
        chk(rem_left == '0, "R13 remaining count in reset", int'(rem_left), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !xferred, "R13 idle after reset", int'(busy), 0);

        run_burst(1, 8,   100, 0, 0, 1);   // R2 R3 read even
        run_burst(1, 7,   100, 1, 0, 2);   // R4 read odd
        run_burst(1, 10,  5,   0, 0, 3);   // R4 R6 odd share with drain
        run_burst(1, 9,   4,   1, 0, 4);   // R6 odd device count drain
        run_burst(1, 6,   0,   0, 0, 5);   // R6 drain only
        run_burst(1, 0,   50,  0, 0, 6);   // R10 read zero
        run_burst(0, 6,   50,  0, 0, 7);   // R3 R7 write even
        run_burst(0, 100, 5,   1, 0, 8);   // R5 R7 write odd
        run_burst(0, 30,  0,   0, 0, 9);   // R10 write zero
        run_burst(1, 259, 300, 1, 0, 10);  // R1 two-register count
        run_burst(0, 512, 513, 0, 0, 11);  // R1 R2 device smaller
        run_burst(0, 100, 40,  1, 1, 12);  // R11 start while busy
        run_burst(1, 300, 301, 0, 0, 13);  // R1 R2 read, host larger
        finish_up();
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog expired", 0, 1);
        finish_up();
    end

endmodule